// File: doc/BRIEF.md
# CAN Physical-Layer Mode and Wake-Up Controller

This block decides how a CAN physical-layer interface operates and what it presents on its receive-data output. It watches a standby-select input, two supply undervoltage flags and a digitised dominant indication from the low-power bus monitor. From these it picks normal operation or a low-power standby, and it forces standby whenever a supply is low. In normal operation the transmit driver and main receiver are enabled, the bus is biased to mid-supply, and RXD follows the main receiver. In standby the driver and receiver are off and the bus is biased to ground. RXD then carries a wake-up request, driven low once the bus has stayed dominant for a programmable number of cycles.

A bus that is already dominant when standby is selected is treated as a stuck bus. Wake-up requests are locked out until the monitor has seen the bus recessive for a full filter period. An undervoltage on the I/O supply releases RXD to high impedance. All inputs are taken as synchronous to `clk`.

The state machine has four states. NORMAL: bus traffic. STANDBY: wake-up filtering. LOCKED: standby with the stuck-bus lockout. FORCED: standby imposed by undervoltage. The transitions are:
- ENTER_STBY: NORMAL to STANDBY, when select is high and the bus is recessive.
- ENTER_LOCK: NORMAL to LOCKED, when select is high and the bus is dominant.
- WAKE_SEL: STANDBY or LOCKED to NORMAL, when select is low.
- UNLOCK: LOCKED to STANDBY, after a recessive run of one filter period.
- UV_TRIP: any state to FORCED, when a supply is low.
- UV_CLEAR: FORCED to NORMAL or STANDBY, according to select.

Top module: `can_mode_ctrl`

## Requirements
- R1: With both supplies good and `stby_sel_i` = 0 sampled at a clock edge, the block is in NORMAL after that edge. In NORMAL, `drv_en_o` = 1 and `rx_en_o` = 1, and `rxd_o` equals `main_rx_i` combinationally (1 = recessive).
- R2: With `stby_sel_i` = 1 (standby) and no undervoltage, the block leaves NORMAL at the next edge, and `drv_en_o` and `rx_en_o` are 0 in every non-NORMAL state.
- R3: `bias_mid_o` is 1 (mid-supply bias) only in NORMAL with both supplies good. Otherwise it is 0 (ground bias).
- R4: In STANDBY, `rxd_o` goes to 0 after FILT_LEN consecutive edges that sample `bus_dom_i` = 1 (1 = dominant). A shorter dominant run gives no request. `rxd_o` returns to 1 after the first edge that samples the bus recessive.
- R5: When `vcc_uv_i` or `vio_uv_i` is 1, driver, receiver and mid bias are disabled in the same cycle, and the next edge enters FORCED regardless of `stby_sel_i`. With only VCC low, wake-up filtering as in R4 runs in FORCED.
- R6: While `vio_uv_i` = 1, `rxd_oe_o` = 0 and `rxd_o` = 1, so no wake-up request reaches RXD. Otherwise `rxd_oe_o` = 1.
- R7: If NORMAL samples `stby_sel_i` = 1 together with `bus_dom_i` = 1, the block enters LOCKED. There `rxd_o` stays 1 however long the bus stays dominant.
- R8: LOCKED moves to STANDBY at the edge after FILT_LEN consecutive recessive samples. Any dominant sample restarts that count, and after the move wake-up filtering resumes as in R4.
- R9: FORCED is left only at an edge where both supplies are good. It goes to NORMAL if `stby_sel_i` = 0 and to STANDBY if `stby_sel_i` = 1.
- R10: While `rst_n` = 0, the block is in STANDBY with the filters cleared: `drv_en_o` = 0, `rx_en_o` = 0, `bias_mid_o` = 0, `rxd_o` = 1, `rxd_oe_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_sel_i | input | 1 | Mode select, 1 = standby, 0 = normal |
| vcc_uv_i | input | 1 | Transceiver supply undervoltage flag |
| vio_uv_i | input | 1 | I/O supply undervoltage flag |
| bus_dom_i | input | 1 | Low-power bus monitor, 1 = dominant |
| main_rx_i | input | 1 | Main receiver data, 1 = recessive |
| drv_en_o | output | 1 | Transmit driver enable |
| rx_en_o | output | 1 | Main receiver enable |
| bias_mid_o | output | 1 | Bus bias select, 1 = mid-supply, 0 = ground |
| rxd_o | output | 1 | RXD data |
| rxd_oe_o | output | 1 | RXD output enable, 0 = high impedance |

## Verification
The bench builds the block with FILT_LEN = 4. This keeps a full dominant qualification, a lockout recessive run and their interruptions within a few dozen cycles. Runs of three and five cycles then land on either side of the threshold, so the off-by-one edges of both filters are exercised. A small filter also makes it cheap to hit every transition, including an undervoltage arriving while a request is held and the release of undervoltage with standby selected.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_LOCKED  = 2'd2,
        MODE_FORCED  = 2'd3
    } mode_e;
endpackage

// File: rtl/cmc_run_filter.sv
// Counts consecutive cycles with level_i high while enabled; saturates at LEN.
module cmc_run_filter #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic level_i,
    output logic done_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(LEN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (en_i && level_i) begin
            cnt_d = (cnt_q == LIM) ? LIM : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import cmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  stby_sel_i,
    input  logic  vcc_uv_i,
    input  logic  vio_uv_i,
    input  logic  bus_dom_i,
    input  logic  rec_done_i,
    output mode_e mode_o
);
    mode_e state_q;
    mode_e state_d;
    logic  any_uv;

    assign any_uv = vcc_uv_i | vio_uv_i;

    always_comb begin
        state_d = state_q;
        if (any_uv) begin
            state_d = MODE_FORCED;                      // UV_TRIP
        end else begin
            unique case (state_q)
                MODE_NORMAL: begin
                    if (stby_sel_i)
                        state_d = bus_dom_i ? MODE_LOCKED : MODE_STANDBY;
                end
                MODE_STANDBY: begin
                    if (!stby_sel_i) state_d = MODE_NORMAL;      // WAKE_SEL
                end
                MODE_LOCKED: begin
                    if (!stby_sel_i)     state_d = MODE_NORMAL;  // WAKE_SEL
                    else if (rec_done_i) state_d = MODE_STANDBY; // UNLOCK
                end
                MODE_FORCED: begin
                    state_d = stby_sel_i ? MODE_STANDBY : MODE_NORMAL; // UV_CLEAR
                end
                default: state_d = MODE_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_STANDBY;
        else        state_q <= state_d;
    end

    assign mode_o = state_q;

    AST_UV_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_uv_i || vio_uv_i) |=> (state_q == MODE_FORCED)); // R5

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NORMAL && stby_sel_i && bus_dom_i && !vcc_uv_i && !vio_uv_i)
        |=> (state_q == MODE_LOCKED)); // R7

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOCKED && stby_sel_i && !rec_done_i && !vcc_uv_i && !vio_uv_i)
        |=> (state_q == MODE_LOCKED)); // R8
endmodule

// File: rtl/cmc_out_sel.sv
module cmc_out_sel
    import cmc_pkg::*;
(
    input  mode_e mode_i,
    input  logic  vcc_uv_i,
    input  logic  vio_uv_i,
    input  logic  main_rx_i,
    input  logic  wake_i,
    output logic  drv_en_o,
    output logic  rx_en_o,
    output logic  bias_mid_o,
    output logic  rxd_o,
    output logic  rxd_oe_o
);
    always_comb begin
        drv_en_o   = 1'b0;
        rx_en_o    = 1'b0;
        bias_mid_o = 1'b0;
        rxd_o      = 1'b1;
        rxd_oe_o   = !vio_uv_i;
        unique case (mode_i)
            MODE_NORMAL: begin
                if (!vcc_uv_i && !vio_uv_i) begin
                    drv_en_o   = 1'b1;
                    rx_en_o    = 1'b1;
                    bias_mid_o = 1'b1;
                    rxd_o      = main_rx_i;
                end
            end
            MODE_STANDBY: rxd_o = vio_uv_i ? 1'b1 : !wake_i;
            MODE_LOCKED:  rxd_o = 1'b1;
            MODE_FORCED:  rxd_o = vio_uv_i ? 1'b1 : !wake_i;
            default:      rxd_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stby_sel_i,
    input  logic vcc_uv_i,
    input  logic vio_uv_i,
    input  logic bus_dom_i,
    input  logic main_rx_i,
    output logic drv_en_o,
    output logic rx_en_o,
    output logic bias_mid_o,
    output logic rxd_o,
    output logic rxd_oe_o
);
    mode_e mode;
    logic  wake_done;
    logic  rec_done;
    logic  wake_en;
    logic  rec_en;

    assign wake_en = (mode == MODE_STANDBY) || (mode == MODE_FORCED && !vio_uv_i);
    assign rec_en  = (mode == MODE_LOCKED);

    cmc_run_filter #(.LEN(FILT_LEN)) u_wake_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (wake_en),
        .level_i (bus_dom_i),
        .done_o  (wake_done)
    );

    cmc_run_filter #(.LEN(FILT_LEN)) u_rec_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (rec_en),
        .level_i (!bus_dom_i),
        .done_o  (rec_done)
    );

    cmc_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_sel_i (stby_sel_i),
        .vcc_uv_i   (vcc_uv_i),
        .vio_uv_i   (vio_uv_i),
        .bus_dom_i  (bus_dom_i),
        .rec_done_i (rec_done),
        .mode_o     (mode)
    );

    cmc_out_sel u_out (
        .mode_i     (mode),
        .vcc_uv_i   (vcc_uv_i),
        .vio_uv_i   (vio_uv_i),
        .main_rx_i  (main_rx_i),
        .wake_i     (wake_done),
        .drv_en_o   (drv_en_o),
        .rx_en_o    (rx_en_o),
        .bias_mid_o (bias_mid_o),
        .rxd_o      (rxd_o),
        .rxd_oe_o   (rxd_oe_o)
    );

    AST_DRV_NEEDS_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> $past(!stby_sel_i)); // R1

    AST_WAKE_NEEDS_DOM: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_oe_o && $past(rxd_oe_o) && mode != MODE_NORMAL && $past(mode) != MODE_NORMAL
         && $fell(rxd_o)) |-> $past(bus_dom_i)); // R4
endmodule

// File: tb/can_mode_ctrl_bench.sv
module can_mode_ctrl_bench;
    localparam int FILT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stby_sel, vcc_uv, vio_uv, bus_dom, main_rx;
    logic drv_en, rx_en, bias_mid, rxd, rxd_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model: 0 normal, 1 standby, 2 locked, 3 forced
    int m_state = 1;
    int m_dom   = 0;
    int m_rec   = 0;

    always #10 clk = ~clk;

    can_mode_ctrl #(.FILT_LEN(FILT)) u_can_mode_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stby_sel_i (stby_sel),
        .vcc_uv_i   (vcc_uv),
        .vio_uv_i   (vio_uv),
        .bus_dom_i  (bus_dom),
        .main_rx_i  (main_rx),
        .drv_en_o   (drv_en),
        .rx_en_o    (rx_en),
        .bias_mid_o (bias_mid),
        .rxd_o      (rxd),
        .rxd_oe_o   (rxd_oe)
    );

    task automatic check(input string tag, input string name, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic vc, input logic vi,
                        input logic d, input logic r);
        logic uv, e_on, e_rxd, wake_on;
        int nxt;
        @(negedge clk);
        stby_sel = s; vcc_uv = vc; vio_uv = vi; bus_dom = d; main_rx = r;
        #1;
        uv = vc | vi;
        e_on = (m_state == 0) && !uv;
        wake_on = ((m_state == 1) || (m_state == 3 && !vi)) && (m_dom >= FILT);
        if (vi)               e_rxd = 1'b1;
        else if (m_state == 0) e_rxd = uv ? 1'b1 : r;
        else                   e_rxd = !wake_on;
        check(tag, "drv_en", drv_en, e_on);
        check(tag, "rx_en", rx_en, e_on);
        check(tag, "bias_mid", bias_mid, e_on);
        check(tag, "rxd", rxd, e_rxd);
        check(tag, "rxd_oe", rxd_oe, !vi);
        @(posedge clk);
        if (!rst_n) begin
            m_state = 1; m_dom = 0; m_rec = 0;
        end else begin
            if (uv) nxt = 3;
            else begin
                case (m_state)
                    0: nxt = s ? (d ? 2 : 1) : 0;
                    1: nxt = s ? 1 : 0;
                    2: nxt = !s ? 0 : ((m_rec >= FILT) ? 1 : 2);
                    default: nxt = s ? 1 : 0;
                endcase
            end
            if (((m_state == 1) || (m_state == 3 && !vi)) && d) m_dom = (m_dom < FILT) ? m_dom + 1 : FILT;
            else m_dom = 0;
            if ((m_state == 2) && !d) m_rec = (m_rec < FILT) ? m_rec + 1 : FILT;
            else m_rec = 0;
            m_state = nxt;
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
        end
    end

    initial begin
        stby_sel = 1'b1; vcc_uv = 1'b0; vio_uv = 1'b0; bus_dom = 1'b0; main_rx = 1'b1;
        // R10 reset state
        repeat (3) step("R10", 1, 0, 0, 0, 1);
        @(negedge clk); rst_n = 1'b1;
        // R2 R3 idle standby
        repeat (3) step("R2", 1, 0, 0, 0, 1);
        // R1 normal, RXD follows receiver
        step("R1", 0, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) step("R1", 0, 0, 0, i[0], i[1] ^ i[2]);
        // R3 bias back to ground on standby entry
        repeat (2) step("R3", 1, 0, 0, 0, 1);
        // R4 short pulse: FILT-1 dominant
        repeat (FILT - 1) step("R4", 1, 0, 0, 1, 1);
        repeat (2) step("R4", 1, 0, 0, 0, 1);
        // R4 qualified dominant, held, then released
        repeat (FILT + 3) step("R4", 1, 0, 0, 1, 1);
        repeat (3) step("R4", 1, 0, 0, 0, 1);
        // R7 enter standby with bus stuck dominant
        repeat (2) step("R1", 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 1, 1);
        repeat (FILT + 4) step("R7", 1, 0, 0, 1, 1);
        // R8 interrupted recessive run, then full run
        repeat (FILT - 1) step("R8", 1, 0, 0, 0, 1);
        step("R8", 1, 0, 0, 1, 1);
        repeat (FILT + 2) step("R8", 1, 0, 0, 0, 1);
        repeat (FILT + 2) step("R8", 1, 0, 0, 1, 1);
        repeat (2) step("R8", 1, 0, 0, 0, 1);
        // R5 VCC undervoltage in normal, then recovery to normal (R9)
        repeat (2) step("R1", 0, 0, 0, 0, 0);
        repeat (2) step("R5", 0, 1, 0, 0, 0);
        repeat (FILT + 2) step("R5", 0, 1, 0, 1, 0);
        step("R5", 0, 1, 0, 0, 0);
        repeat (3) step("R9", 0, 0, 0, 0, 0);
        // R6 VIO undervoltage during qualified wake
        repeat (2) step("R2", 1, 0, 0, 0, 1);
        repeat (FILT + 1) step("R6", 1, 0, 0, 1, 1);
        repeat (FILT + 3) step("R6", 1, 0, 1, 1, 1);
        step("R6", 0, 0, 1, 0, 0);
        // R9 release with standby selected, then both good with select low
        step("R9", 1, 0, 0, 0, 1);
        repeat (2) step("R9", 1, 0, 0, 0, 1);
        step("R9", 1, 1, 1, 0, 1);
        step("R9", 0, 0, 0, 0, 0);
        repeat (3) step("R9", 0, 0, 0, 0, 1);
        finished = 1'b1;
        report();
    end
endmodule